// File: doc/BRIEF.md
# Multi-Mode Trigger Generator

This block turns one of several event sources into a single-clock trigger pulse for a test bench that stimulates readout electronics. A 3-bit mode input selects the source: each strobe of a pattern pulser, a divided-down stream of those strobes, a free-running internal timer, a pseudo-random generator, a flag bit carried in the pulser's pattern word, or an asynchronous external input. Only the selected source can produce triggers.

Triggers are issued only while the spill-enable input is high, so the trigger stream can be confined to a spill window. Every issued trigger also advances a 32-bit running count. The timer and the random generator run on their own and have no timing relation to the pulser. The downscaler and the timer restart from zero whenever the mode input changes.

Top module: `trig_gen`

## Requirements
- R1: In mode 0, each clock cycle with `pulseStb` high produces a trigger. `trigOut` is high in the clock cycle that follows the strobe cycle.
- R2: In mode 1 with `downscale` = N ≥ 2, a trigger is issued on the N-th, 2N-th, 3N-th and later strobes. With N equal to 0 or 1, every strobe produces a trigger.
- R3: Any change of the `mode` input clears the downscale count. After the block returns to mode 1, counting starts again from the first strobe. A strobe in the same cycle as the mode change is not counted.
- R4: In mode 2 with `period` = P ≥ 1, triggers come from an internal timer exactly P cycles apart and need no strobe. P = 0 gives no triggers.
- R5: In mode 3, a trigger is issued in each cycle where the low 16 bits of a free-running 32-bit LFSR (feedback taps 32, 22, 2, 1) are below `threshold`. The LFSR never holds zero. A threshold of 0 gives no triggers, and a threshold of 0x8000 gives triggers in about half of the cycles.
- R6: In mode 4, a strobe issues a trigger only when bit 31 of `pulseWord` is 1. Bit 31 set without a strobe does nothing, and the other word bits are ignored.
- R7: In mode 5, `extTrig` passes through a two-flop synchronizer and a rising-edge detector. Each rising edge gives exactly one trigger, one clock wide, however long the input stays high. `trigOut` rises in the third clock cycle after the edge is applied.
- R8: Modes 6 and 7 never produce a trigger, and `trigCount` stays unchanged in them.
- R9: While `spillEn` is low, no trigger is issued and `trigCount` does not change.
- R10: `trigCount` goes up by exactly one in each cycle where `trigOut` is high, and stays unchanged in all other cycles.
- R11: After reset, `trigOut` is 0 and `trigCount` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 3 | Trigger source select (0 each, 1 downscale, 2 timer, 3 random, 4 word bit, 5 external, 6–7 off) |
| downscale | input | 16 | Strobes per trigger in mode 1 |
| period | input | 16 | Timer period in cycles for mode 2 |
| threshold | input | 16 | Random-mode compare threshold |
| spillEn | input | 1 | Spill window open; gates all triggers |
| pulseStb | input | 1 | Pulser timeslot strobe, one cycle per slot |
| pulseWord | input | 32 | Pattern word valid with the strobe |
| extTrig | input | 1 | Asynchronous external trigger |
| trigOut | output | 1 | Trigger pulse |
| trigCount | output | 32 | Number of triggers issued since reset |

## Verification
The assertions assume that `mode` is a stable configuration value and that `downscale` and `period` are not lowered while their counters run. A reduction in mid-count could leave a counter above its new limit for one cycle. The directed stimulus writes configuration only while the affected source is idle, and then waits a few cycles before it sends strobes. The assertions also assume that `extTrig` is held for at least one full cycle. The bench keeps it high or low for several cycles, so the synchronizer always sees each level.

// File: rtl/trig_pkg.sv
package trig_pkg;

  localparam logic [2:0] MODE_EACH  = 3'd0;
  localparam logic [2:0] MODE_DOWN  = 3'd1;
  localparam logic [2:0] MODE_TIMER = 3'd2;
  localparam logic [2:0] MODE_RAND  = 3'd3;
  localparam logic [2:0] MODE_MEM   = 3'd4;
  localparam logic [2:0] MODE_EXT   = 3'd5;
  localparam logic [2:0] MODE_OFF   = 3'd7;

  // per-source fire strobes, control -> datapath
  typedef struct packed {
    logic each;
    logic down;
    logic timer;
    logic rnd;
    logic mem;
    logic ext;
  } srcFire_t;

endpackage

// File: rtl/trig_lfsr.sv
module trig_lfsr #(
  parameter int          WIDTH = 32,
  parameter logic [31:0] TAPS  = 32'h8020_0003,
  parameter logic [31:0] SEED  = 32'hACE1_2B3D
) (
  input  logic             clk,
  input  logic             rstN,
  output logic [WIDTH-1:0] state
);

  localparam logic [WIDTH-1:0] tapMask  = TAPS[WIDTH-1:0];
  localparam logic [WIDTH-1:0] seedVal  = SEED[WIDTH-1:0];

  logic feedBack;
  assign feedBack = ^(state & tapMask);

  always_ff @(posedge clk) begin
    if (!rstN) state <= seedVal;
    else       state <= {state[WIDTH-2:0], feedBack};
  end

  // R5: a maximal-length register must never lock up at zero
  assert_lfsr_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    state != '0);

endmodule

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int DS_W    = 16,
  parameter int TMR_W   = 16,
  parameter int RND_W   = 16,
  parameter int WORD_W  = 32,
  parameter int MEM_BIT = WORD_W - 1,
  parameter int LFSR_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        mode,
  input  logic [DS_W-1:0]   downscale,
  input  logic [TMR_W-1:0]  period,
  input  logic [RND_W-1:0]  threshold,
  input  logic              pulseStb,
  input  logic [WORD_W-1:0] pulseWord,
  input  logic              extTrig,
  output srcFire_t          fire
);

  // mode tracking: any change restarts the counters
  logic [2:0] modeQ;
  logic       modeChg;
  assign modeChg = (mode != modeQ);

  always_ff @(posedge clk) begin
    if (!rstN) modeQ <= MODE_OFF;
    else       modeQ <= mode;
  end

  // downscaler
  logic [DS_W-1:0] dsCnt;
  logic            dsPass;
  logic            dsHit;
  assign dsPass = (downscale <= DS_W'(1));
  assign dsHit  = dsPass || (dsCnt >= downscale - DS_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || modeChg)                 dsCnt <= '0;
    else if (mode == MODE_DOWN && pulseStb) dsCnt <= dsHit ? '0 : dsCnt + DS_W'(1);
  end

  // periodic timer, free of pulser timing
  logic [TMR_W-1:0] tmrCnt;
  logic             tmrHit;
  assign tmrHit = (period != '0) && (tmrCnt >= period - TMR_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN || modeChg)        tmrCnt <= '0;
    else if (mode == MODE_TIMER) tmrCnt <= tmrHit ? '0 : tmrCnt + TMR_W'(1);
  end

  // random source
  logic [LFSR_W-1:0] lfsrState;
  trig_lfsr #(.WIDTH(LFSR_W)) uLfsr (
    .clk   (clk),
    .rstN  (rstN),
    .state (lfsrState)
  );

  // external input: two-flop synchronizer plus edge history
  logic extMeta, extSync, extPrev, extRise;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      extMeta <= 1'b0;
      extSync <= 1'b0;
      extPrev <= 1'b0;
    end else begin
      extMeta <= extTrig;
      extSync <= extMeta;
      extPrev <= extSync;
    end
  end
  assign extRise = extSync & ~extPrev;

  always_comb begin
    fire.each  = (mode == MODE_EACH) && pulseStb;
    fire.down  = (mode == MODE_DOWN) && !modeChg && pulseStb && dsHit;
    fire.timer = (mode == MODE_TIMER) && !modeChg && tmrHit;
    fire.rnd   = (mode == MODE_RAND) && (lfsrState[RND_W-1:0] < threshold);
    fire.mem   = (mode == MODE_MEM) && pulseStb && pulseWord[MEM_BIT];
    fire.ext   = (mode == MODE_EXT) && extRise;
  end

  // R7: an external edge yields a single-cycle request
  assert_ext_one_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    fire.ext |=> !fire.ext);

  // R3: a mode change restarts both counters
  assert_counters_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    modeChg |=> (dsCnt == '0 && tmrCnt == '0));

  // R4: a zero period never produces a timer request
  assert_timer_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    (period == '0) |-> !fire.timer);

  // R6: no strobe, no memory trigger request
  assert_mem_needs_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    !pulseStb |-> !fire.mem);

endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       mode,
  input  logic             spillEn,
  input  srcFire_t         fire,
  output logic             trigOut,
  output logic [CNT_W-1:0] trigCount
);

  logic selFire;
  logic nextTrig;

  always_comb begin
    case (mode)
      MODE_EACH:  selFire = fire.each;
      MODE_DOWN:  selFire = fire.down;
      MODE_TIMER: selFire = fire.timer;
      MODE_RAND:  selFire = fire.rnd;
      MODE_MEM:   selFire = fire.mem;
      MODE_EXT:   selFire = fire.ext;
      default:    selFire = 1'b0;
    endcase
  end

  assign nextTrig = spillEn && selFire;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigOut   <= 1'b0;
      trigCount <= '0;
    end else begin
      trigOut <= nextTrig;
      if (nextTrig) trigCount <= trigCount + CNT_W'(1);
    end
  end

  // R9: a closed spill window blocks the next trigger
  assert_spill_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    !spillEn |=> !trigOut);

  // R10: count steps by one with each trigger
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> (trigCount == $past(trigCount) + CNT_W'(1)));

  // R10: count holds without a trigger
  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !trigOut |-> $stable(trigCount));

  // R8: reserved modes are silent
  assert_bad_mode_R8: assert property (@(posedge clk) disable iff (!rstN)
    (mode > MODE_EXT) |=> !trigOut);

endmodule

// File: rtl/trig_gen.sv
module trig_gen
  import trig_pkg::*;
#(
  parameter int DS_W   = 16,
  parameter int TMR_W  = 16,
  parameter int RND_W  = 16,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        mode,
  input  logic [DS_W-1:0]   downscale,
  input  logic [TMR_W-1:0]  period,
  input  logic [RND_W-1:0]  threshold,
  input  logic              spillEn,
  input  logic              pulseStb,
  input  logic [WORD_W-1:0] pulseWord,
  input  logic              extTrig,
  output logic              trigOut,
  output logic [CNT_W-1:0]  trigCount
);

  srcFire_t fire;

  trig_ctrl #(
    .DS_W   (DS_W),
    .TMR_W  (TMR_W),
    .RND_W  (RND_W),
    .WORD_W (WORD_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .downscale (downscale),
    .period    (period),
    .threshold (threshold),
    .pulseStb  (pulseStb),
    .pulseWord (pulseWord),
    .extTrig   (extTrig),
    .fire      (fire)
  );

  trig_datapath #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .mode      (mode),
    .spillEn   (spillEn),
    .fire      (fire),
    .trigOut   (trigOut),
    .trigCount (trigCount)
  );

endmodule

// File: tb/tb_trig_gen.sv
`timescale 1ns/1ps
module tb_trig_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  mode = 3'd7;
  logic [15:0] downscale = '0;
  logic [15:0] period = '0;
  logic [15:0] threshold = '0;
  logic        spillEn = 1'b0;
  logic        pulseStb = 1'b0;
  logic [31:0] pulseWord = '0;
  logic        extTrig = 1'b0;
  logic        trigOut;
  logic [31:0] trigCount;

  int checks = 0;
  int fails  = 0;
  int seen   = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  trig_gen dut (
    .clk(clk), .rstN(rstN), .mode(mode), .downscale(downscale),
    .period(period), .threshold(threshold), .spillEn(spillEn),
    .pulseStb(pulseStb), .pulseWord(pulseWord), .extTrig(extTrig),
    .trigOut(trigOut), .trigCount(trigCount)
  );

  // trigger monitor, sampled away from the rising edge
  always @(negedge clk) if (rstN && trigOut) seen++;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic [31:0] w);
    @(negedge clk);
    pulseStb  = 1'b1;
    pulseWord = w;
    @(negedge clk);
    pulseStb  = 1'b0;
    pulseWord = '0;
  endtask

  task automatic setMode(input logic [2:0] m);
    @(negedge clk);
    mode = m;
    idle(2);
  endtask

  task automatic testReset();
    check(trigOut == 1'b0, "R11 trigOut", trigOut, 0);
    check(trigCount == 0, "R11 trigCount", trigCount, 0);
  endtask

  task automatic testEach();
    int s0;
    setMode(3'd0);
    @(negedge clk); pulseStb = 1'b1;
    @(negedge clk); pulseStb = 1'b0;
    check(trigOut == 1'b1, "R1 latency", trigOut, 1);
    @(negedge clk);
    check(trigOut == 1'b0, "R1 width", trigOut, 0);
    s0 = seen;
    for (int i = 0; i < 5; i++) strobe(32'h0);
    idle(2);
    check(seen - s0 == 5, "R1 count", seen - s0, 5);
  endtask

  task automatic testDown();
    int s0;
    downscale = 16'd3;
    setMode(3'd1);
    s0 = seen;
    strobe(0); strobe(0); idle(1);
    check(seen - s0 == 0, "R2 before Nth", seen - s0, 0);
    strobe(0); idle(1);
    check(seen - s0 == 1, "R2 on Nth", seen - s0, 1);
    for (int i = 0; i < 6; i++) strobe(0);
    idle(2);
    check(seen - s0 == 3, "R2 N=3 nine strobes", seen - s0, 3);
    downscale = 16'd0; idle(2);
    s0 = seen;
    for (int i = 0; i < 4; i++) strobe(0);
    idle(2);
    check(seen - s0 == 4, "R2 N=0", seen - s0, 4);
    downscale = 16'd1; idle(2);
    s0 = seen;
    for (int i = 0; i < 4; i++) strobe(0);
    idle(2);
    check(seen - s0 == 4, "R2 N=1", seen - s0, 4);
  endtask

  task automatic testDownRestart();
    int s0;
    downscale = 16'd4;
    setMode(3'd0);
    setMode(3'd1);
    s0 = seen;
    strobe(0); strobe(0);
    setMode(3'd0);
    setMode(3'd1);
    strobe(0); strobe(0); strobe(0); idle(1);
    check(seen - s0 == 0, "R3 restart no early trigger", seen - s0, 0);
    strobe(0); idle(2);
    check(seen - s0 == 1, "R3 restart fires on 4th", seen - s0, 1);
  endtask

  task automatic testTimer();
    int n;
    int s0;
    period = 16'd7;
    setMode(3'd2);
    n = 0;
    while (!trigOut && n < 100) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!trigOut && n < 100);
    check(n == 7, "R4 spacing P=7", n, 7);
    n = 0;
    do begin @(negedge clk); n++; end while (!trigOut && n < 100);
    check(n == 7, "R4 spacing repeat", n, 7);
    period = 16'd0;
    idle(3);
    s0 = seen;
    idle(50);
    check(seen - s0 == 0, "R4 P=0 silent", seen - s0, 0);
  endtask

  task automatic testRandom();
    int s0;
    int d;
    threshold = 16'd0;
    setMode(3'd3);
    s0 = seen;
    idle(500);
    check(seen - s0 == 0, "R5 threshold 0", seen - s0, 0);
    threshold = 16'h8000;
    idle(2);
    s0 = seen;
    idle(2000);
    d = seen - s0;
    check(d >= 800 && d <= 1200, "R5 threshold half", d, 1000);
    threshold = 16'hFFFF;
    idle(2);
    s0 = seen;
    idle(1000);
    d = seen - s0;
    check(d >= 990, "R5 threshold max", d, 1000);
    threshold = 16'd0;
    idle(2);
  endtask

  task automatic testMem();
    int s0;
    setMode(3'd4);
    s0 = seen;
    for (int i = 0; i < 3; i++) strobe(32'h8000_0000);
    for (int i = 0; i < 3; i++) strobe(32'h7FFF_FFFF);
    @(negedge clk); pulseWord = 32'hFFFF_FFFF;
    idle(3); pulseWord = '0;
    idle(2);
    check(seen - s0 == 3, "R6 bit31 with strobe", seen - s0, 3);
  endtask

  task automatic testExt();
    int s0;
    setMode(3'd5);
    s0 = seen;
    @(negedge clk); extTrig = 1'b1;
    @(negedge clk);
    check(trigOut == 1'b0, "R7 not at cycle 1", trigOut, 0);
    @(negedge clk);
    check(trigOut == 1'b0, "R7 not at cycle 2", trigOut, 0);
    @(negedge clk);
    check(trigOut == 1'b1, "R7 at cycle 3", trigOut, 1);
    @(negedge clk);
    check(trigOut == 1'b0, "R7 one clock wide", trigOut, 0);
    idle(8);
    check(seen - s0 == 1, "R7 held level one trigger", seen - s0, 1);
    extTrig = 1'b0; idle(4);
    extTrig = 1'b1; idle(4);
    extTrig = 1'b0; idle(4);
    check(seen - s0 == 2, "R7 second edge", seen - s0, 2);
  endtask

  task automatic testOff();
    int s0;
    logic [31:0] c0;
    period = 16'd1;
    threshold = 16'hFFFF;
    for (int m = 6; m < 8; m++) begin
      setMode(3'(m));
      s0 = seen;
      c0 = trigCount;
      strobe(32'h8000_0000);
      extTrig = 1'b1; idle(5); extTrig = 1'b0; idle(5);
      check(seen - s0 == 0, "R8 reserved mode silent", seen - s0, 0);
      check(trigCount == c0, "R8 count frozen", trigCount, c0);
    end
    period = 16'd0;
    threshold = 16'd0;
  endtask

  task automatic testSpill();
    int s0;
    logic [31:0] c0;
    setMode(3'd0);
    spillEn = 1'b0;
    s0 = seen;
    c0 = trigCount;
    for (int i = 0; i < 4; i++) strobe(0);
    idle(2);
    check(seen - s0 == 0, "R9 no trigger outside spill", seen - s0, 0);
    check(trigCount == c0, "R9 count held outside spill", trigCount, c0);
    spillEn = 1'b1;
    strobe(0); idle(2);
    check(seen - s0 == 1, "R9 trigger after reopen", seen - s0, 1);
  endtask

  task automatic testCount();
    check(trigCount == 32'(seen), "R10 count equals observed", trigCount, seen);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(4);
    testReset();
    @(negedge clk); rstN = 1'b1; spillEn = 1'b1;
    idle(2);
    testReset();
    testEach();
    testDown();
    testDownRestart();
    testTimer();
    testRandom();
    testMem();
    testExt();
    testOff();
    testSpill();
    setMode(3'd7);
    idle(2);
    testCount();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule